// File: doc/BRIEF.md
# Recovered-Clock Frequency Lock Detector

This block decides whether a recovered serial clock runs close enough in frequency to a local reference clock for a clock-recovery loop to be trusted. Over a fixed window of reference cycles it counts recovered-clock cycles. The count is compared with the nominal value, which is the divider ratio times the window length. A count inside a symmetric tolerance band sets an active-high lock flag. A count outside the band clears it.

An active-low control input, `lock_ref_n`, is synchronous to `ref_clk`. While it is low, the loop must train to the reference and the lock flag is held low. When it goes high, the block does four things in order:

- It points the training select at the incoming data.
- It waits a settling interval.
- It runs back-to-back measurement windows.
- If no lock is seen within the acquisition interval, it sends the loop back to the reference for one settling interval and then retries.

The window boundaries cross into the recovered-clock domain as a toggle. The count crosses back only after an acknowledge toggle has returned, so the multi-bit value is never sampled while it is changing.

The control state machine has four states:

- `ST_HOLD_REF`: reset state, select on reference, lock low.
- `ST_SETTLE`: select on data, waiting `SETTLE_CYCLES`.
- `ST_MEASURE`: windows running, lock updated at each window end.
- `ST_RETRAIN`: select on reference for `SETTLE_CYCLES` after a failed acquisition.

It has these transitions:

- Any state goes to `ST_HOLD_REF` whenever `lock_ref_n` is low.
- `ST_HOLD_REF` goes to `ST_SETTLE` when `lock_ref_n` is high.
- `ST_SETTLE` goes to `ST_MEASURE` when the settle count ends.
- `ST_MEASURE` goes to `ST_RETRAIN` when the lock flag has been low for `ACQ_CYCLES`.
- `ST_RETRAIN` goes to `ST_SETTLE` when the settle count ends.

Top module: `reclk_lock_detect`

## Requirements
- R1: After reset, `lock_o` is 0 and `train_ref_o` is 1.
- R2: In any cycle where `lock_ref_n` is 0, `lock_o` is 0 in that same cycle. From the next `ref_clk` edge on, `train_ref_o` is 1.
- R3: `train_ref_o` only changes from 1 to 0 while `lock_ref_n` is 1. After `lock_ref_n` rises, `train_ref_o` is 0 from the next edge, except during a retrain interval (R7).
- R4: After the block enters settling, `lock_o` stays 0 for at least `SETTLE_CYCLES` + `WIN_CYCLES` reference cycles. With a recovered clock in tolerance, `lock_o` is 1 within roughly 40 cycles after that.
- R5: A window lasts `WIN_CYCLES` reference cycles. The count it produces is the number of recovered-clock cycles in the window. With NOM = `DIV_RATIO`·`WIN_CYCLES` and TOL = floor(NOM·`TOL_PERMILLE`/1000), a count strictly between NOM−TOL and NOM+TOL sets `lock_o` to 1. With the defaults, NOM = 20480 and TOL = 327, which is 1.6 %.
- R6: A count of NOM−TOL or less, or of NOM+TOL or more, sets `lock_o` to 0, for offsets in either direction. `lock_o` rises only at the end of a window.
- R7: If `lock_o` stays 0 for `ACQ_CYCLES` reference cycles while measuring, `train_ref_o` goes to 1 for `SETTLE_CYCLES` cycles. It does not do this earlier. The block then settles and measures again.
- R8: Asserting `rst_n` low clears `lock_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock |
| rec_clk | input | 1 | Recovered clock from the loop, nominally `DIV_RATIO` times `ref_clk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_ref_n | input | 1 | Active-low request to train to the reference, synchronous to `ref_clk` |
| lock_o | output | 1 | Active-high frequency lock flag |
| train_ref_o | output | 1 | 1: loop follows the reference; 0: loop follows the data |

## Verification
The recovered clock is driven at the nominal ratio, at ±1.0 % and ±1.55 % (inside the band), at ±1.62 % (just past the 1.6 % edge) and at ±3 %. These settings separate a correct strict band from an off-by-one bound, and separate a symmetric check from a one-sided one. Holding +3 % until the acquisition interval expires measures when the retrain begins and how long it lasts. Dropping `lock_ref_n` and `rst_n` while locked shows the flag clears at once. The settle-plus-window delay is measured after each release.

// File: rtl/flk_pkg.sv
package flk_pkg;
    timeunit 1ns;
    timeprecision 1fs;

    typedef enum logic [1:0] {
        ST_HOLD_REF = 2'd0,
        ST_SETTLE   = 2'd1,
        ST_MEASURE  = 2'd2,
        ST_RETRAIN  = 2'd3
    } flk_state_e;
endpackage

// File: rtl/flk_sync.sv
module flk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    timeunit 1ns;
    timeprecision 1fs;

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/flk_rec_count.sv
module flk_rec_count #(
    parameter int CNT_W       = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic             rec_clk,
    input  logic             rec_rst_n,
    input  logic             win_tgl,
    output logic [CNT_W-1:0] cnt_hold,
    output logic             ack_tgl
);
    timeunit 1ns;
    timeprecision 1fs;

    logic             win_s;
    logic             win_d;
    logic             win_edge;
    logic [CNT_W-1:0] run_cnt;

    flk_sync #(.STAGES(SYNC_STAGES)) u_win_sync (
        .clk   (rec_clk),
        .rst_n (rec_rst_n),
        .d     (win_tgl),
        .q     (win_s)
    );

    assign win_edge = win_s ^ win_d;

    always_ff @(posedge rec_clk or negedge rec_rst_n) begin
        if (!rec_rst_n) begin
            win_d    <= 1'b0;
            run_cnt  <= '0;
            cnt_hold <= '0;
            ack_tgl  <= 1'b0;
        end else begin
            win_d <= win_s;
            if (win_edge) begin
                cnt_hold <= run_cnt;
                run_cnt  <= CNT_W'(1);
                ack_tgl  <= ~ack_tgl;
            end else if (run_cnt != '1) begin
                run_cnt <= run_cnt + CNT_W'(1);
            end
        end
    end

    // R5
    ack_after_boundary_chk: assert property (@(posedge rec_clk) disable iff (!rec_rst_n)
        !$stable(ack_tgl) |-> $past(win_edge));

    // R5
    hold_steady_chk: assert property (@(posedge rec_clk) disable iff (!rec_rst_n)
        !$past(win_edge) |-> $stable(cnt_hold));
endmodule

// File: rtl/flk_ctrl.sv
module flk_ctrl
    import flk_pkg::*;
#(
    parameter int WIN_CYCLES    = 1024,
    parameter int SETTLE_CYCLES = 532,
    parameter int ACQ_CYCLES    = 42500,
    parameter int CNT_W         = 17,
    parameter int NOM_COUNT     = 20480,
    parameter int TOL_COUNT     = 327,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             lock_ref_n,
    input  logic [CNT_W-1:0] cnt_hold,
    input  logic             ack_tgl,
    output logic             win_tgl,
    output logic             lock_q,
    output logic             train_ref_o
);
    timeunit 1ns;
    timeprecision 1fs;

    localparam int WIN_W = $clog2(WIN_CYCLES);
    localparam int TMR_W = $clog2(SETTLE_CYCLES + 1);
    localparam int ACQ_W = $clog2(ACQ_CYCLES + 1);
    localparam logic [CNT_W-1:0] LO_BOUND = CNT_W'(NOM_COUNT - TOL_COUNT);
    localparam logic [CNT_W-1:0] HI_BOUND = CNT_W'(NOM_COUNT + TOL_COUNT);

    flk_state_e       state, next_state;
    logic [TMR_W-1:0] tmr;
    logic [WIN_W-1:0] win_cnt;
    logic [ACQ_W-1:0] acq_cnt;
    logic             ack_s, ack_d, ack_edge;
    logic             first_q;
    logic             tmr_done, win_done, acq_done, in_range;

    flk_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    assign ack_edge = ack_s ^ ack_d;
    assign tmr_done = (tmr == TMR_W'(SETTLE_CYCLES - 1));
    assign win_done = (win_cnt == WIN_W'(WIN_CYCLES - 1));
    assign acq_done = (acq_cnt == ACQ_W'(ACQ_CYCLES - 1));
    assign in_range = (cnt_hold > LO_BOUND) && (cnt_hold < HI_BOUND);

    // next-state logic
    always_comb begin
        next_state = state;
        if (!lock_ref_n) begin
            next_state = ST_HOLD_REF;
        end else begin
            unique case (state)
                ST_HOLD_REF: next_state = ST_SETTLE;
                ST_SETTLE:   if (tmr_done) next_state = ST_MEASURE;
                ST_MEASURE:  if (acq_done && !lock_q) next_state = ST_RETRAIN;
                ST_RETRAIN:  if (tmr_done) next_state = ST_SETTLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD_REF;
        else        state <= next_state;
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_HOLD_REF, ST_RETRAIN: train_ref_o = 1'b1;
            ST_SETTLE, ST_MEASURE:   train_ref_o = 1'b0;
        endcase
    end

    // timers, window boundaries and result capture
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr     <= '0;
            win_cnt <= '0;
            acq_cnt <= '0;
            ack_d   <= 1'b0;
            first_q <= 1'b0;
            win_tgl <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            ack_d <= ack_s;

            if (state != next_state) tmr <= '0;
            else if (state == ST_SETTLE || state == ST_RETRAIN) tmr <= tmr + TMR_W'(1);

            if (state == ST_SETTLE && next_state == ST_MEASURE) begin
                win_tgl <= ~win_tgl;
                win_cnt <= '0;
                first_q <= 1'b1;
            end else if (state == ST_MEASURE && next_state == ST_MEASURE) begin
                if (win_done) begin
                    win_cnt <= '0;
                    win_tgl <= ~win_tgl;
                end else begin
                    win_cnt <= win_cnt + WIN_W'(1);
                end
            end

            if (state == ST_MEASURE && ack_edge && first_q) first_q <= 1'b0;

            if (next_state != ST_MEASURE) lock_q <= 1'b0;
            else if (state == ST_MEASURE && ack_edge && !first_q) lock_q <= in_range;

            if (state != ST_MEASURE || lock_q) acq_cnt <= '0;
            else if (!acq_done) acq_cnt <= acq_cnt + ACQ_W'(1);
        end
    end

    // R2
    hold_ref_sel_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !lock_ref_n |=> train_ref_o);

    // R3
    data_sel_only_released_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(train_ref_o) |-> lock_ref_n);

    // R4
    no_lock_outside_measure_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state != ST_MEASURE) |-> !lock_q);

    // R6
    lock_rise_at_window_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(ack_edge));

    // R7
    acq_bound_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        acq_cnt < ACQ_W'(ACQ_CYCLES));

    // R7
    retrain_cause_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == ST_RETRAIN && $past(state) == ST_MEASURE) |-> !$past(lock_q));
endmodule

// File: rtl/reclk_lock_detect.sv
module reclk_lock_detect #(
    parameter int DIV_RATIO     = 20,
    parameter int WIN_CYCLES    = 1024,
    parameter int TOL_PERMILLE  = 16,
    parameter int SETTLE_CYCLES = 532,
    parameter int ACQ_CYCLES    = 42500,
    parameter int SYNC_STAGES   = 2
) (
    input  logic ref_clk,
    input  logic rec_clk,
    input  logic rst_n,
    input  logic lock_ref_n,
    output logic lock_o,
    output logic train_ref_o
);
    timeunit 1ns;
    timeprecision 1fs;

    localparam int NOM_COUNT = DIV_RATIO * WIN_CYCLES;
    localparam int TOL_COUNT = (NOM_COUNT * TOL_PERMILLE) / 1000;
    localparam int CNT_W     = $clog2(NOM_COUNT) + 2;

    logic             rec_rst_n;
    logic             win_tgl;
    logic             ack_tgl;
    logic             lock_q;
    logic [CNT_W-1:0] cnt_hold;

    flk_sync #(.STAGES(SYNC_STAGES)) u_rec_rst (
        .clk   (rec_clk),
        .rst_n (rst_n),
        .d     (1'b1),
        .q     (rec_rst_n)
    );

    flk_rec_count #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_count (
        .rec_clk   (rec_clk),
        .rec_rst_n (rec_rst_n),
        .win_tgl   (win_tgl),
        .cnt_hold  (cnt_hold),
        .ack_tgl   (ack_tgl)
    );

    flk_ctrl #(
        .WIN_CYCLES    (WIN_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .ACQ_CYCLES    (ACQ_CYCLES),
        .CNT_W         (CNT_W),
        .NOM_COUNT     (NOM_COUNT),
        .TOL_COUNT     (TOL_COUNT),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_ctrl (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .lock_ref_n  (lock_ref_n),
        .cnt_hold    (cnt_hold),
        .ack_tgl     (ack_tgl),
        .win_tgl     (win_tgl),
        .lock_q      (lock_q),
        .train_ref_o (train_ref_o)
    );

    assign lock_o = lock_q & lock_ref_n;
endmodule

// File: tb/tb_reclk_lock_detect.sv
module tb_reclk_lock_detect;
    timeunit 1ns;
    timeprecision 1fs;

    localparam int SETTLE = 532;
    localparam int WIN    = 1024;
    localparam int ACQ    = 8000;
    localparam int NOM_B  = 20 * WIN;
    localparam int TOL_B  = (NOM_B * 16) / 1000;

    logic ref_clk = 1'b0;
    logic rec_clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_ref_n = 1'b0;
    logic lock_o, train_ref_o;
    real  rec_half = 0.2;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int fall_cyc = 0;
    logic prev_lock = 1'b0;
    bit   finished = 1'b0;

    bit    mon_en = 1'b0;
    logic  mon_lock = 1'b0;
    string mon_req = "R5";
    bit    sel_en = 1'b0;
    logic  sel_exp = 1'b0;
    string sel_req = "R3";

    reclk_lock_detect #(
        .SETTLE_CYCLES (SETTLE),
        .WIN_CYCLES    (WIN),
        .ACQ_CYCLES    (ACQ)
    ) dut (
        .ref_clk     (ref_clk),
        .rec_clk     (rec_clk),
        .rst_n       (rst_n),
        .lock_ref_n  (lock_ref_n),
        .lock_o      (lock_o),
        .train_ref_o (train_ref_o)
    );

    always #4 ref_clk = ~ref_clk;
    always begin
        #(rec_half);
        rec_clk = ~rec_clk;
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_range(input string req, input string what, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // behavioural reference: expected lock from the frequency offset
    function automatic logic lock_for(input real p);
        real cnt, d;
        cnt = NOM_B * (1.0 + p);
        d = (cnt > NOM_B) ? cnt - NOM_B : NOM_B - cnt;
        return (d < TOL_B) ? 1'b1 : 1'b0;
    endfunction

    // per-cycle comparison against the model
    always @(negedge ref_clk) begin
        cyc++;
        if (prev_lock === 1'b1 && lock_o === 1'b0) fall_cyc = cyc;
        prev_lock = lock_o;
        if (mon_en) check(mon_req, "lock_o", lock_o, mon_lock);
        if (sel_en) check(sel_req, "train_ref_o", train_ref_o, sel_exp);
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic run_phase(input real p, input string req);
        rec_half = 0.2 / (1.0 + p);
        mon_en = 1'b0;
        cycles(2100);
        mon_lock = lock_for(p);
        mon_req = req;
        mon_en = 1'b1;
        cycles(1990);
        mon_en = 1'b0;
    endtask

    initial begin
        #(150000 * 8);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int waited;
        int t0;
        cycles(5);
        // R1
        check("R1", "lock_o in reset", lock_o, 1'b0);
        check("R1", "train_ref_o in reset", train_ref_o, 1'b1);
        #1 rst_n = 1'b1;
        cycles(20);
        // R2
        check("R2", "train_ref_o held", train_ref_o, 1'b1);
        check("R2", "lock_o held", lock_o, 1'b0);
        #1 lock_ref_n = 1'b1;
        cycles(2);
        // R3
        check("R3", "train_ref_o after release", train_ref_o, 1'b0);
        cycles(SETTLE + WIN - 10);
        // R4
        check("R4", "lock_o before first window", lock_o, 1'b0);
        cycles(50);
        check("R4", "lock_o after first window", lock_o, 1'b1);

        sel_exp = 1'b0; sel_req = "R3"; sel_en = 1'b1;
        run_phase(0.0,    "R5");
        run_phase(0.010,  "R5");
        run_phase(0.0162, "R6");
        run_phase(-0.010, "R5");
        run_phase(-0.0162,"R6");
        run_phase(0.0155, "R5");
        run_phase(-0.0155,"R5");
        run_phase(0.03,   "R6");
        run_phase(0.0,    "R5");
        run_phase(-0.03,  "R6");
        run_phase(0.0,    "R5");
        sel_en = 1'b0;

        // R7: acquisition timeout and retrain
        check("R7", "locked before timeout test", lock_o, 1'b1);
        rec_half = 0.2 / 1.03;
        waited = 0;
        while (train_ref_o !== 1'b1 && waited < 14000) begin
            @(negedge ref_clk);
            waited++;
        end
        check_range("R7", "cycles from lock loss to retrain", cyc - fall_cyc, ACQ - 1, ACQ + 2);
        rec_half = 0.2;
        t0 = cyc;
        while (train_ref_o === 1'b1 && cyc - t0 < 3000) @(negedge ref_clk);
        check_range("R7", "retrain length", cyc - t0, SETTLE - 1, SETTLE + 1);
        cycles(1500);
        check("R7", "lock_o during re-measure", lock_o, 1'b0);
        cycles(100);
        check("R7", "lock_o after retrain", lock_o, 1'b1);
        cycles(500);

        // R2: forcing the control low while locked
        check("R2", "locked before force", lock_o, 1'b1);
        #1 lock_ref_n = 1'b0;
        #1 check("R2", "lock_o same cycle", lock_o, 1'b0);
        cycles(1);
        check("R2", "train_ref_o after force", train_ref_o, 1'b1);
        mon_lock = 1'b0; mon_req = "R2"; mon_en = 1'b1;
        sel_exp = 1'b1; sel_req = "R2"; sel_en = 1'b1;
        cycles(2000);
        mon_en = 1'b0; sel_en = 1'b0;
        #1 lock_ref_n = 1'b1;
        cycles(2);
        check("R3", "train_ref_o after second release", train_ref_o, 1'b0);
        mon_lock = 1'b0; mon_req = "R4"; mon_en = 1'b1;
        cycles(SETTLE + WIN - 10);
        mon_en = 1'b0;
        cycles(60);
        check("R4", "lock_o after settle and window", lock_o, 1'b1);

        // R8: asynchronous reset while locked
        cycles(100);
        #1 rst_n = 1'b0;
        #1 check("R8", "lock_o on async reset", lock_o, 1'b0);
        check("R8", "train_ref_o on async reset", train_ref_o, 1'b1);
        cycles(5);
        #1 rst_n = 1'b1;
        cycles(SETTLE + WIN - 10);
        check("R8", "lock_o before relock", lock_o, 1'b0);
        cycles(60);
        check("R8", "lock_o after relock", lock_o, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule